// File: doc/BRIEF.md
# Receive Frame Readout Window

This block holds one received Ethernet frame and lets a host fetch it through a small set of fixed word locations inside a 4 KB byte-addressed window. A receive-side port streams the frame in as 16-bit words. Closing the frame supplies its status word and its byte count. From that moment the frame is held, a receive event waits in a one-entry event queue, and an interrupt is raised while the host has the receive interrupt enabled.

The host services the frame in a fixed order. It reads the queue location, which hands over the event and clears it. It then reads the status word, then the length word. Last, it reads the frame contents as successive words from the data base offset. The block keeps its own readout position and advances it once per data read. After the last word that covers the byte count has been read, the frame is freed and the next frame can be accepted. A frame that finishes while another one is still held is discarded, and a missed-frame counter records it.

Top module: `rx_readout_win`

## Requirements
- R1: After reset, irq is 0, miss_cnt is 0, rd_vld is 0, rd_data is 0, and a read of the queue location returns 0.
- R2: Closing a frame (dep_done while no frame is held) sets a pending receive event. irq equals irq_en AND pending, so irq is 1 from the clock after dep_done when irq_en is 1. With irq_en at 0, irq stays 0 and the event still waits in the queue.
- R3: A read at byte offset 0x120 returns the event code 0x0004 when an event is pending and removes it, which drops irq. A read at 0x120 with no event pending returns 0x0000.
- R4: While a frame is held, a read at 0x400 returns the status word given with dep_done.
- R5: While a frame is held, a read at 0x402 returns the byte length given with dep_done.
- R6: Reads at any even offset from 0x404 upward return the frame words in the order they were deposited. Each such read advances the readout position by exactly one word.
- R7: The frame stays held until ceil(length/2) data words have been read. The read of the last such word frees it. After that, reads at 0x400 and 0x402 return 0.
- R8: A data read while no frame is held returns 0 and does not move the readout position.
- R9: dep_done while a frame is held drops the new frame: miss_cnt increments by one (modulo 2^MISS_W), and the held frame's status and remaining data are unchanged.
- R10: Once a frame has been freed, the next dep_done is accepted as a new frame and the readout position restarts at its first word.
- R11: rd_data and rd_vld are registered. They carry the result in the cycle after rd_en is high and are 0 in the cycle after rd_en is low. A read of an unmapped or odd offset returns 0.
- R12: A held frame with length 0 needs no data words. Its first data read returns 0 and frees it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Receive interrupt enable |
| dep_vld | input | 1 | Receive-side frame word valid |
| dep_word | input | 16 | Receive-side frame word |
| dep_done | input | 1 | Close the frame being deposited |
| dep_status | input | 16 | Status word, taken with dep_done |
| dep_len | input | 16 | Frame length in bytes, taken with dep_done |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 12 | Host byte offset inside the window |
| rd_data | output | 16 | Read result, one cycle after rd_en |
| rd_vld | output | 1 | Read result valid |
| irq | output | 1 | Receive interrupt |
| miss_cnt | output | MISS_W | Count of frames dropped while busy |

## Verification
The hardest state to reach is a second frame closing while the first is still only partly read. The host's reads must stop partway through the data, and a complete second frame must be pushed in at that point. The bench does exactly this: it leaves two words of a held frame unread, deposits a full frame with a different status and different words, then reads the rest. This shows the counter moved while the held status and the remaining words did not. A zero-length frame and an odd byte count are also driven, so the release point is tested on both sides of the rounding.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned CNT_W  = 17;

    localparam logic [ADDR_W-1:0] OFS_QUEUE = 12'h120;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_LEN   = 12'h402;
    localparam logic [ADDR_W-1:0] OFS_DATA  = 12'h404;

    localparam logic [WORD_W-1:0] EVT_RX_CODE = 16'h0004;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_QUEUE,
        SEL_STAT,
        SEL_LEN,
        SEL_DATA
    } sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] len;
    } hdr_t;

    function automatic sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        if (a == OFS_QUEUE)               return SEL_QUEUE;
        else if (a == OFS_STAT)           return SEL_STAT;
        else if (a == OFS_LEN)            return SEL_LEN;
        else if (a >= OFS_DATA && !a[0])  return SEL_DATA;
        else                              return SEL_NONE;
    endfunction

    function automatic logic [CNT_W-1:0] words_for(input logic [WORD_W-1:0] nbytes);
        return ({1'b0, nbytes} + CNT_W'(1)) >> 1;
    endfunction

endpackage

// File: rtl/rxw_frame_store.sv
module rxw_frame_store
    import rxw_pkg::*;
#(
    parameter int unsigned DEPTH = 760
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_rewind,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wptr;
    logic              room;

    assign room = (wptr < PW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
        end else if (wr_rewind) begin
            wptr <= '0;
        end else if (wr_en && room) begin
            wptr <= wptr + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && room) begin
            mem[wptr[AW-1:0]] <= wr_data;
        end
    end

    always_comb begin
        if (rd_idx < CNT_W'(DEPTH)) rd_word = mem[rd_idx[AW-1:0]];
        else                        rd_word = '0;
    end

endmodule

// File: rtl/rxw_event_q.sv
module rxw_event_q (
    input  logic clk,
    input  logic rst,
    input  logic post,
    input  logic pop,
    input  logic irq_en,
    output logic pending,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) pending <= 1'b0;
        else     pending <= post | (pending & ~pop);
    end

    assign irq = irq_en & pending;

endmodule

// File: rtl/rxw_host_port.sv
module rxw_host_port
    import rxw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              held,
    input  logic              restart,
    input  hdr_t              hdr,
    input  logic              ev_pending,
    input  logic [WORD_W-1:0] mem_word,
    output logic [CNT_W-1:0]  pos,
    output logic              ev_pop,
    output logic              frame_free,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_vld
);
    sel_e              sel;
    logic [CNT_W-1:0]  need;
    logic [WORD_W-1:0] nxt;
    logic              adv;

    assign sel  = decode_ofs(rd_addr);
    assign need = words_for(hdr.len);

    always_comb begin
        nxt        = '0;
        ev_pop     = 1'b0;
        frame_free = 1'b0;
        adv        = 1'b0;
        if (rd_en) begin
            unique case (sel)
                SEL_QUEUE: begin
                    nxt    = ev_pending ? EVT_RX_CODE : '0;
                    ev_pop = 1'b1;
                end
                SEL_STAT: nxt = held ? hdr.status : '0;
                SEL_LEN:  nxt = held ? hdr.len    : '0;
                SEL_DATA: begin
                    if (held) begin
                        if (pos < need) begin
                            nxt        = mem_word;
                            adv        = 1'b1;
                            frame_free = ((pos + CNT_W'(1)) == need);
                        end else begin
                            frame_free = 1'b1;
                        end
                    end
                end
                default: nxt = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
            pos     <= '0;
        end else begin
            rd_data <= nxt;
            rd_vld  <= rd_en;
            if (restart)  pos <= '0;
            else if (adv) pos <= pos + CNT_W'(1);
        end
    end

endmodule

// File: rtl/rx_readout_win.sv
module rx_readout_win
    import rxw_pkg::*;
#(
    parameter int unsigned DEPTH  = 760,
    parameter int unsigned MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_en,
    input  logic              dep_vld,
    input  logic [15:0]       dep_word,
    input  logic              dep_done,
    input  logic [15:0]       dep_status,
    input  logic [15:0]       dep_len,
    input  logic              rd_en,
    input  logic [11:0]       rd_addr,
    output logic [15:0]       rd_data,
    output logic              rd_vld,
    output logic              irq,
    output logic [MISS_W-1:0] miss_cnt
);
    logic              frame_held;
    logic              commit;
    logic              drop;
    logic              frame_free;
    logic              ev_pending;
    logic              ev_pop;
    hdr_t              hdr;
    logic [CNT_W-1:0]  pos;
    logic [WORD_W-1:0] mem_word;

    assign commit = dep_done & ~frame_held;
    assign drop   = dep_done &  frame_held;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_held <= 1'b0;
            hdr        <= '0;
            miss_cnt   <= '0;
        end else begin
            if (commit) begin
                frame_held <= 1'b1;
                hdr        <= '{status: dep_status, len: dep_len};
            end else if (frame_free) begin
                frame_held <= 1'b0;
            end
            if (drop) miss_cnt <= miss_cnt + MISS_W'(1);
        end
    end

    rxw_frame_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (dep_vld & ~frame_held),
        .wr_data   (dep_word),
        .wr_rewind (dep_done),
        .rd_idx    (pos),
        .rd_word   (mem_word)
    );

    rxw_event_q u_evq (
        .clk     (clk),
        .rst     (rst),
        .post    (commit),
        .pop     (ev_pop),
        .irq_en  (irq_en),
        .pending (ev_pending),
        .irq     (irq)
    );

    rxw_host_port u_host (
        .clk        (clk),
        .rst        (rst),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .held       (frame_held),
        .restart    (commit),
        .hdr        (hdr),
        .ev_pending (ev_pending),
        .mem_word   (mem_word),
        .pos        (pos),
        .ev_pop     (ev_pop),
        .frame_free (frame_free),
        .rd_data    (rd_data),
        .rd_vld     (rd_vld)
    );

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int unsigned MISS_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_en,
    input logic              dep_done,
    input logic              rd_en,
    input logic [11:0]       rd_addr,
    input logic [15:0]       rd_data,
    input logic              rd_vld,
    input logic              irq,
    input logic [MISS_W-1:0] miss_cnt,
    input logic              frame_held
);
    // R2
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en);

    // R3
    queue_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 12'h120 && !(dep_done && !frame_held)) |=> !irq);

    // R8
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr >= 12'h404 && !rd_addr[0] && !frame_held) |=> rd_data == 16'h0000);

    // R9
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (dep_done && frame_held) |=> miss_cnt == MISS_W'($past(miss_cnt) + 1'b1));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (dep_done && !frame_held) |=> frame_held);

    // R11
    read_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_vld);

    // R11
    read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_vld && rd_data == 16'h0000));

endmodule

bind rx_readout_win rxw_checker #(.MISS_W(MISS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_en     (irq_en),
    .dep_done   (dep_done),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .rd_vld     (rd_vld),
    .irq        (irq),
    .miss_cnt   (miss_cnt),
    .frame_held (frame_held)
);

// File: tb/sim_rx_readout_win.sv
`timescale 1ns/1ps
module sim_rx_readout_win;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_en = 1'b1;
    logic        dep_vld = 1'b0;
    logic [15:0] dep_word = '0;
    logic        dep_done = 1'b0;
    logic [15:0] dep_status = '0;
    logic [15:0] dep_len = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_vld;
    logic        irq;
    logic [7:0]  miss_cnt;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rx_readout_win u0 (
        .clk(clk), .rst(rst), .irq_en(irq_en),
        .dep_vld(dep_vld), .dep_word(dep_word), .dep_done(dep_done),
        .dep_status(dep_status), .dep_len(dep_len),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_vld(rd_vld), .irq(irq), .miss_cnt(miss_cnt)
    );

    // behavioural reference model
    bit          m_held, m_pend, m_vld;
    int          m_ptr, m_miss;
    logic [15:0] m_rd, m_stat, m_len;
    logic [15:0] m_buf[$];
    logic [15:0] m_frame[$];

    always @(posedge clk) begin
        if (rst) begin
            m_held = 0; m_pend = 0; m_vld = 0; m_ptr = 0; m_miss = 0;
            m_rd = '0; m_stat = '0; m_len = '0;
            m_buf.delete(); m_frame.delete();
        end else begin
            bit h0;
            logic [15:0] d;
            h0 = m_held;
            d = '0;
            if (rd_en) begin
                if (rd_addr == 12'h120) begin
                    d = m_pend ? 16'h0004 : 16'h0000;
                    m_pend = 0;
                end else if (rd_addr == 12'h400) begin
                    d = h0 ? m_stat : 16'h0000;
                end else if (rd_addr == 12'h402) begin
                    d = h0 ? m_len : 16'h0000;
                end else if (rd_addr >= 12'h404 && !rd_addr[0] && h0) begin
                    int need;
                    need = (int'(m_len) + 1) / 2;
                    if (m_ptr < need) begin
                        d = (m_ptr < m_frame.size()) ? m_frame[m_ptr] : 16'h0000;
                        m_ptr++;
                        if (m_ptr == need) m_held = 0;
                    end else begin
                        m_held = 0;
                    end
                end
            end
            m_rd = d;
            m_vld = rd_en;
            if (dep_vld && !h0) m_buf.push_back(dep_word);
            if (dep_done) begin
                if (h0) begin
                    m_miss = (m_miss + 1) % 256;
                end else begin
                    m_held = 1; m_pend = 1; m_ptr = 0;
                    m_stat = dep_status; m_len = dep_len;
                    m_frame = m_buf;
                end
                m_buf.delete();
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_chk++;
            if (rd_data !== m_rd || rd_vld !== m_vld ||
                irq !== (irq_en & m_pend) || miss_cnt !== 8'(m_miss)) begin
                n_err++;
                $display("FAIL R11 model compare: act data=%h vld=%b irq=%b miss=%0d exp data=%h vld=%b irq=%b miss=%0d",
                         rd_data, rd_vld, irq, miss_cnt, m_rd, m_vld, irq_en & m_pend, m_miss);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); #1;
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk); #1;
        rd_en = 1'b0;
        chk(rd_vld === 1'b1 && rd_data === exp, tag, {15'd0, rd_vld, rd_data}, {16'd1, exp});
    endtask

    task automatic deposit(input logic [15:0] w[$], input logic [15:0] st, input logic [15:0] ln);
        foreach (w[i]) begin
            @(negedge clk); #1;
            dep_vld = 1'b1; dep_word = w[i];
        end
        @(negedge clk); #1;
        dep_vld = 1'b0;
        dep_done = 1'b1; dep_status = st; dep_len = ln;
        @(negedge clk); #1;
        dep_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: act=timeout exp=finish");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] fa[$], fb[$], fc[$], fd[$], fz[$];
        fa = '{16'h1111, 16'h2222, 16'h3333};
        fb = '{16'hA0A0, 16'hB0B0, 16'hC0C0};
        fc = '{16'hDEAD, 16'hBEEF};
        fd = '{16'h5A5A};
        fz = '{};
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk(irq === 1'b0 && miss_cnt === 8'd0 && rd_vld === 1'b0 && rd_data === 16'h0,
            "R1 reset outputs", {7'd0, irq, miss_cnt, rd_data}, 32'h0);
        rd_chk(12'h120, 16'h0000, "R1 empty queue after reset");

        // frame A: 5 bytes, 3 words
        deposit(fa, 16'h8001, 16'd5);
        chk(irq === 1'b1, "R2 irq raised", {31'd0, irq}, 32'd1);
        rd_chk(12'h120, 16'h0004, "R3 queue event");
        chk(irq === 1'b0, "R3 irq released", {31'd0, irq}, 32'd0);
        rd_chk(12'h120, 16'h0000, "R3 queue empty");
        rd_chk(12'h400, 16'h8001, "R4 status");
        rd_chk(12'h402, 16'd5, "R5 length");
        rd_chk(12'h404, 16'h1111, "R6 word0");
        rd_chk(12'h406, 16'h2222, "R6 word1");
        rd_chk(12'h400, 16'h8001, "R7 still held before last word");
        rd_chk(12'h408, 16'h3333, "R7 odd length last word");
        rd_chk(12'h400, 16'h0000, "R7 status cleared after release");
        rd_chk(12'h402, 16'h0000, "R7 length cleared after release");
        rd_chk(12'h404, 16'h0000, "R8 data read while idle");
        rd_chk(12'h404, 16'h0000, "R8 idle read repeated");

        // frame B with interrupt masked, then a drop while held
        irq_en = 1'b0;
        deposit(fb, 16'h4242, 16'd6);
        chk(irq === 1'b0, "R2 irq masked", {31'd0, irq}, 32'd0);
        rd_chk(12'h120, 16'h0004, "R2 event queued while masked");
        irq_en = 1'b1;
        rd_chk(12'h404, 16'hA0A0, "R6 frame B word0");
        deposit(fc, 16'h9999, 16'd4);
        chk(miss_cnt === 8'd1, "R9 miss count", {24'd0, miss_cnt}, 32'd1);
        chk(irq === 1'b0, "R9 no event for dropped frame", {31'd0, irq}, 32'd0);
        rd_chk(12'h400, 16'h4242, "R9 held status unchanged");
        rd_chk(12'h406, 16'hB0B0, "R9 held word1 unchanged");
        rd_chk(12'h408, 16'hC0C0, "R9 held word2 unchanged");
        rd_chk(12'h400, 16'h0000, "R7 even length release");

        // frame D accepted after release
        deposit(fd, 16'h0101, 16'd2);
        chk(irq === 1'b1, "R10 new frame irq", {31'd0, irq}, 32'd1);
        rd_chk(12'h120, 16'h0004, "R10 new event");
        rd_chk(12'h402, 16'd2, "R10 new length");
        rd_chk(12'h404, 16'h5A5A, "R10 readout restarts at first word");
        rd_chk(12'h404, 16'h0000, "R8 read past end");

        // R12 zero-length frame
        deposit(fz, 16'h7777, 16'd0);
        rd_chk(12'h400, 16'h7777, "R12 zero length held");
        rd_chk(12'h404, 16'h0000, "R12 zero length data read");
        rd_chk(12'h400, 16'h0000, "R12 released after one read");
        rd_chk(12'h120, 16'h0004, "R12 event still pending");

        // R11 unmapped and odd offsets
        rd_chk(12'h200, 16'h0000, "R11 unmapped offset");
        deposit(fd, 16'h0202, 16'd2);
        rd_chk(12'h405, 16'h0000, "R11 odd offset");
        rd_chk(12'h404, 16'h5A5A, "R11 odd read did not advance");
        @(negedge clk); #1;
        chk(rd_vld === 1'b0 && rd_data === 16'h0, "R11 idle cycle", {15'd0, rd_vld, rd_data}, 32'h0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule